// File: doc/BRIEF.md
# Dual-Compare Alternating Timer

An 8-bit up-counter that checks two compare registers in turn. After each start it compares against the first register, then the second, then the first again, and so on. Each register has its own action mask, so one register can set the pulse width and the other the space width of a PWM-like signal on a toggling output flip-flop. A match can clear the counter, raise a one-cycle timer interrupt and toggle the output. Any combination of the three is allowed. A register can also be marked one-shot, so that it acts only once per start and leaves the rotation afterwards.

The count-enable comes either from the system clock or from rising edges of a synchronised external clock pin. A separate external input can hold a started counter idle until its active edge arrives (trigger mode). The active edge, rising or falling, is selectable. While the timer is stopped, the same edge can raise an input interrupt. The timer is set up through a simple write port. Stopping the timer clears the counter, reloads the chosen idle level into the output and restores the rotation to its starting point.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset all settings are zero and `out_ff`, `tmr_irq` and `ext_irq` are low.
- R2: Write addresses are control 0, clock select 1, compare A 2, compare B 3, mask A 4 and mask B 5. Once started, compares alternate A, B, A, B. With the clear bit set, a match at count C returns the counter to 0 in place of C+1, so C+1 count ticks separate consecutive matches.
- R3: Mask bits: bit0 clears the counter, bit1 raises the timer interrupt, bit2 toggles `out_ff`. An action whose bit is zero does not happen, and a match without clear lets the counter continue from C to C+1.
- R4: Without clear the counter wraps from 255 to 0, and each match still hands the next compare to the other register.
- R5: Mask bit3 (one-shot) makes a register's match act only once per start. After that, every compare uses the other register.
- R6: With both registers one-shot, exactly two matches occur per start.
- R7: Control bit2 (trigger mode) keeps a started counter idle until an active edge on `ext_in`.
- R8: Control bit0 is the run bit. While it is 0 the counter is cleared, the one-shot flags are re-armed, compare A is selected and `out_ff` follows control bit1.
- R9: Clock-select bit0 set makes the counter advance once per rising edge of `ext_clk`, after a two-stage synchroniser. When it is clear, the counter advances every system clock.
- R10: Clock-select bit1 picks the active edge of `ext_in`: 0 for rising, 1 for falling. The other edge has no effect.
- R11: With control bit3 set and the run bit clear, each active `ext_in` edge gives a one-cycle `ext_irq` pulse. No pulse is given while running.
- R12: `tmr_irq` is a one-cycle pulse for each match whose interrupt bit is set, and it occurs only while running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| ext_clk | input | 1 | External count clock (asynchronous) |
| ext_in | input | 1 | External trigger / interrupt input (asynchronous) |
| out_ff | output | 1 | Output flip-flop |
| tmr_irq | output | 1 | Compare-match interrupt pulse |
| ext_irq | output | 1 | External-input interrupt pulse |

## Verification
The hardest state to reach from the ports is the rotation after one-shot registers have fired. There the effective register differs from the nominal one, and only timing at `out_ff` reveals which register is in use. The bench starts the timer with one or both registers one-shot and compares against a behavioural model on every clock. It also counts output toggles over a long window after both one-shot registers have fired. The wrap case needs the counter to pass 255 without clearing. The bench reaches it by leaving the clear bit off both registers and measuring the 246-cycle low phase.

// File: rtl/dct_pkg.sv
// Package: shared field layouts and address map of the dual-compare timer.
// Assumes registers are at least 4 bits wide.
package dct_pkg;

    localparam int unsigned ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_CLKS  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CMPA  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CMPB  = 3'd3;
    localparam logic [ADDR_W-1:0] A_MASKA = 3'd4;
    localparam logic [ADDR_W-1:0] A_MASKB = 3'd5;

    // per-register match actions
    typedef struct packed {
        logic one_shot;
        logic toggle;
        logic irq;
        logic clear;
    } act_mask_t;

    // control settings
    typedef struct packed {
        logic in_irq_en;
        logic trig_mode;
        logic idle_lvl;
        logic run;
    } ctrl_t;

    // clock source settings
    typedef struct packed {
        logic fall_edge;
        logic ext_src;
    } clksel_t;

endpackage

// File: rtl/dct_sync_edge.sv
// Module: multi-stage synchroniser with rising/falling edge detect.
// Assumes din is asynchronous to clk; edges are one clk wide.
module dct_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] shr;

    genvar g;
    generate
        for (g = 0; g <= STAGES; g++) begin : g_stage
            // one flop of the synchroniser / history chain
            always_ff @(posedge clk) begin
                if (!rst_n) shr[g] <= 1'b0;
                else        shr[g] <= (g == 0) ? din : shr[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    // edge decode on the last synchronised stage versus its history
    assign rise = shr[STAGES-1] & ~shr[STAGES];
    assign fall = ~shr[STAGES-1] & shr[STAGES];
endmodule

// File: rtl/dct_regs.sv
// Module: write-only settings store for the timer.
// Assumes one write per cycle; new values act from the next cycle.
module dct_regs
    import dct_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [CNT_W-1:0]       wr_data,
    output ctrl_t                  ctrl,
    output clksel_t                clks,
    output logic [1:0][CNT_W-1:0]  cmp,
    output act_mask_t [1:0]        mask
);
    // capture writes into the addressed field
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
            clks <= '0;
            cmp  <= '0;
            mask <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_CTRL:  ctrl    <= ctrl_t'(wr_data[3:0]);
                A_CLKS:  clks    <= clksel_t'(wr_data[1:0]);
                A_CMPA:  cmp[0]  <= wr_data;
                A_CMPB:  cmp[1]  <= wr_data;
                A_MASKA: mask[0] <= act_mask_t'(wr_data[3:0]);
                A_MASKB: mask[1] <= act_mask_t'(wr_data[3:0]);
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dct_core.sv
// Module: counter, alternating compare selection, one-shot tracking,
// trigger gate and output flip-flop.
// Assumes tick and trig_edge are single-cycle pulses in the clk domain.
module dct_core
    import dct_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick,
    input  logic                   trig_edge,
    input  ctrl_t                  ctrl,
    input  logic [1:0][CNT_W-1:0]  cmp,
    input  act_mask_t [1:0]        mask,
    output logic                   out_ff,
    output logic                   tmr_irq,
    output logic [CNT_W-1:0]       cnt,
    output logic [1:0]             done,
    output logic                   trig_seen
);
    logic      sel;
    logic      esel;
    logic      active;
    logic      hit;
    act_mask_t am;

    // effective register: skip one that has already fired as one-shot
    always_comb begin
        esel   = done[sel] ? ~sel : sel;
        am     = mask[esel];
        active = ctrl.run & (~ctrl.trig_mode | trig_seen);
        hit    = active & tick & ~done[esel] & (cnt == cmp[esel]);
    end

    // counting, match actions and stop-time re-initialisation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            sel       <= 1'b0;
            done      <= '0;
            trig_seen <= 1'b0;
            out_ff    <= 1'b0;
            tmr_irq   <= 1'b0;
        end else if (!ctrl.run) begin
            cnt       <= '0;
            sel       <= 1'b0;
            done      <= '0;
            trig_seen <= 1'b0;
            out_ff    <= ctrl.idle_lvl;
            tmr_irq   <= 1'b0;
        end else begin
            tmr_irq <= hit & am.irq;
            if (ctrl.trig_mode && !trig_seen && trig_edge) trig_seen <= 1'b1;
            if (active && tick) begin
                if (hit) begin
                    cnt         <= am.clear ? '0 : cnt + 1'b1;
                    sel         <= ~esel;
                    done[esel]  <= done[esel] | am.one_shot;
                    out_ff      <= out_ff ^ am.toggle;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dual_cmp_timer.sv
// Module: top of the dual-compare alternating timer.
// Assumes ext_clk and ext_in are asynchronous; all else is clk-synchronous.
module dual_cmp_timer
    import dct_pkg::*;
#(
    parameter int unsigned CNT_W       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              ext_clk,
    input  logic              ext_in,
    output logic              out_ff,
    output logic              tmr_irq,
    output logic              ext_irq
);
    ctrl_t                 ctrl;
    clksel_t               clks;
    logic [1:0][CNT_W-1:0] cmp;
    act_mask_t [1:0]       mask;
    logic                  ck_rise, ck_fall;
    logic                  in_rise, in_fall;
    logic                  tick, in_edge;
    logic [CNT_W-1:0]      cnt;
    logic [1:0]            done;
    logic                  trig_seen;
    logic                  run_w, trig_w, idle_w;

    dct_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ctrl(ctrl), .clks(clks), .cmp(cmp), .mask(mask)
    );

    dct_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_clk (
        .clk(clk), .rst_n(rst_n), .din(ext_clk), .rise(ck_rise), .fall(ck_fall)
    );

    dct_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_in (
        .clk(clk), .rst_n(rst_n), .din(ext_in), .rise(in_rise), .fall(in_fall)
    );

    // count-enable source and active input edge selection
    always_comb begin
        tick    = clks.ext_src ? ck_rise : 1'b1;
        in_edge = clks.fall_edge ? in_fall : in_rise;
        run_w   = ctrl.run;
        trig_w  = ctrl.trig_mode;
        idle_w  = ctrl.idle_lvl;
    end

    dct_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .trig_edge(in_edge),
        .ctrl(ctrl), .cmp(cmp), .mask(mask), .out_ff(out_ff),
        .tmr_irq(tmr_irq), .cnt(cnt), .done(done), .trig_seen(trig_seen)
    );

    // input-edge interrupt, only while stopped
    always_ff @(posedge clk) begin
        if (!rst_n) ext_irq <= 1'b0;
        else        ext_irq <= in_edge & ~ctrl.run & ctrl.in_irq_en;
    end

    logic unused_fall;
    assign unused_fall = ck_fall;
endmodule

// File: rtl/dct_checker.sv
// Module: temporal checks on the timer, bound into the top.
// Assumes it sees the top's settings and core state through the bind.
module dct_checker #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             trig_mode,
    input logic             idle_lvl,
    input logic             trig_seen,
    input logic [CNT_W-1:0] cnt,
    input logic [1:0]       done,
    input logic             out_ff,
    input logic             tmr_irq,
    input logic             ext_irq
);
    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0)); // R8
    AST_STOP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (out_ff == $past(idle_lvl))); // R8
    AST_TRIG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && trig_mode && !trig_seen) |=> $stable(cnt)); // R7
    AST_ONESHOT_HOLD_A: assert property (@(posedge clk) disable iff (!rst_n)
        (run && done[0]) |=> done[0]); // R5
    AST_ONESHOT_HOLD_B: assert property (@(posedge clk) disable iff (!rst_n)
        (run && done[1]) |=> done[1]); // R5
    AST_EXT_IRQ_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        ext_irq |-> $past(!run)); // R11
    AST_TMR_IRQ_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_irq |-> $past(run)); // R12
endmodule

bind dual_cmp_timer dct_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run_w), .trig_mode(trig_w),
    .idle_lvl(idle_w), .trig_seen(trig_seen), .cnt(cnt), .done(done),
    .out_ff(out_ff), .tmr_irq(tmr_irq), .ext_irq(ext_irq)
);

// File: tb/tb_dual_cmp_timer.sv
module tb_dual_cmp_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       ext_clk = 1'b0;
    logic       ext_in = 1'b0;
    logic       out_ff, tmr_irq, ext_irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done_flag = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    dual_cmp_timer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ext_clk(ext_clk), .ext_in(ext_in),
        .out_ff(out_ff), .tmr_irq(tmr_irq), .ext_irq(ext_irq)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_ctrl, m_clks, m_cnt, m_sel;
    int m_cmp[2];
    int m_mask[2];
    bit m_done[2];
    bit m_seen, m_out, m_tirq, m_xirq;
    bit mc[3];
    bit mi[3];

    always @(posedge clk) begin
        bit tick, iedge, run, act, hit;
        int eff;
        cycles++;
        if (!rst_n) begin
            m_ctrl = 0; m_clks = 0; m_cnt = 0; m_sel = 0;
            m_cmp = '{0, 0}; m_mask = '{0, 0}; m_done = '{0, 0};
            m_seen = 0; m_out = 0; m_tirq = 0; m_xirq = 0;
            mc = '{0, 0, 0}; mi = '{0, 0, 0};
        end else begin
            tick  = m_clks[0] ? (mc[1] && !mc[2]) : 1'b1;
            iedge = m_clks[1] ? (!mi[1] && mi[2]) : (mi[1] && !mi[2]);
            run   = m_ctrl[0];
            m_xirq = iedge && !run && m_ctrl[3];
            if (!run) begin
                m_cnt = 0; m_sel = 0; m_done = '{0, 0}; m_seen = 0;
                m_out = m_ctrl[1]; m_tirq = 0;
            end else begin
                act = !m_ctrl[2] || m_seen;
                if (m_ctrl[2] && !m_seen && iedge) m_seen = 1;
                eff = m_done[m_sel] ? 1 - m_sel : m_sel;
                hit = act && tick && !m_done[eff] && (m_cnt == m_cmp[eff]);
                m_tirq = hit && m_mask[eff][1];
                if (act && tick) begin
                    if (hit) begin
                        m_cnt = m_mask[eff][0] ? 0 : (m_cnt + 1) % 256;
                        m_sel = 1 - eff;
                        if (m_mask[eff][3]) m_done[eff] = 1;
                        if (m_mask[eff][2]) m_out = !m_out;
                    end else begin
                        m_cnt = (m_cnt + 1) % 256;
                    end
                end
            end
            mc[2] = mc[1]; mc[1] = mc[0]; mc[0] = ext_clk;
            mi[2] = mi[1]; mi[1] = mi[0]; mi[0] = ext_in;
            if (wr_en) begin
                case (wr_addr)
                    3'd0: m_ctrl = wr_data & 8'hF;
                    3'd1: m_clks = wr_data & 8'h3;
                    3'd2: m_cmp[0] = wr_data;
                    3'd3: m_cmp[1] = wr_data;
                    3'd4: m_mask[0] = wr_data & 8'hF;
                    3'd5: m_mask[1] = wr_data & 8'hF;
                    default: ;
                endcase
            end
        end
    end

    // per-cycle comparison against the model, plus event counters
    int tog_cnt = 0, irq_cnt = 0, xirq_cnt = 0;
    bit last_out = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            check({out_ff, tmr_irq, ext_irq} == {m_out, m_tirq, m_xirq}, cur_req,
                  "outputs {out,tirq,xirq} vs model",
                  int'({out_ff, tmr_irq, ext_irq}), int'({m_out, m_tirq, m_xirq}));
            if (out_ff != last_out) tog_cnt++;
            if (tmr_irq) irq_cnt++;
            if (ext_irq) xirq_cnt++;
        end
        last_out = out_ff;
    end

    // external clock generator, period 8 system clocks
    bit eclk_on = 0;
    int ediv = 0;
    always @(negedge clk) begin
        if (eclk_on) begin
            ediv++;
            if (ediv == 4) begin ext_clk = ~ext_clk; ediv = 0; end
        end
    end

    // watchdog
    always @(negedge clk) begin
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            finish_run();
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1; wr_addr = a[2:0]; wr_data = d[7:0];
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // length in cycles of the next run of out_ff at level lvl
    task automatic measure(input bit lvl, output int len);
        int guard = 0;
        len = 0;
        while (out_ff != lvl && guard < 4000) begin @(negedge clk); guard++; end
        while (out_ff == lvl && len < 4000) begin @(negedge clk); len++; end
    endtask

    task automatic setup(input int ca, input int cb, input int ma, input int mb);
        wr(0, 0);
        wr(2, ca); wr(3, cb); wr(4, ma); wr(5, mb);
    endtask

    initial begin
        int w;
        int base;
        idle(3);
        rst_n = 1;
        @(negedge clk);
        cur_req = "R1";
        check(out_ff == 0, "R1", "out_ff after reset", out_ff, 0);
        check(tmr_irq == 0, "R1", "tmr_irq after reset", tmr_irq, 0);
        check(ext_irq == 0, "R1", "ext_irq after reset", ext_irq, 0);
        idle(5);

        // R2 / R12: PWM, A=3 B=5 with clear+irq+toggle
        cur_req = "R2/R12";
        setup(3, 5, 7, 7);
        wr(0, 1);
        measure(1, w); check(w == 6, "R2", "high width", w, 6);
        measure(0, w); check(w == 4, "R2", "low width", w, 4);
        base = irq_cnt; idle(20);
        check(irq_cnt - base == 4, "R12", "irq pulses in 20 cycles", irq_cnt - base, 4);

        // R3: A irq only (no clear), B clear+irq+toggle
        cur_req = "R3";
        setup(4, 6, 2, 7);
        wr(0, 1);
        measure(1, w); check(w == 7, "R3", "period with A clear masked", w, 7);
        base = tog_cnt; wr(4, 0); idle(40);
        check(tog_cnt - base == 6 || tog_cnt - base == 5, "R3", "toggles with A silent",
              tog_cnt - base, 6);

        // R4: no clear, wrap
        cur_req = "R4";
        setup(10, 20, 4, 4);
        wr(0, 1);
        measure(1, w); check(w == 10, "R4", "high width", w, 10);
        measure(0, w); check(w == 246, "R4", "low width across wrap", w, 246);

        // R5: A one-shot
        cur_req = "R5";
        setup(2, 4, 13, 5);
        wr(0, 1);
        measure(1, w); check(w == 5, "R5", "first high width", w, 5);
        measure(0, w); check(w == 5, "R5", "B-only low width", w, 5);
        measure(1, w); check(w == 5, "R5", "B-only high width", w, 5);

        // R6: both one-shot
        cur_req = "R6";
        setup(2, 3, 13, 13);
        base = tog_cnt;
        wr(0, 1);
        idle(600);
        check(tog_cnt - base == 2, "R6", "toggles per start", tog_cnt - base, 2);
        check(out_ff == 0, "R6", "final level", out_ff, 0);

        // R8: stop reloads idle level 1
        cur_req = "R8";
        wr(0, 2);
        idle(2);
        check(out_ff == 1, "R8", "idle level after stop", out_ff, 1);
        wr(0, 3); idle(3);
        wr(0, 2); idle(2);
        check(out_ff == 1, "R8", "idle level after restop", out_ff, 1);

        // R7 / R10: trigger on falling edge
        cur_req = "R7/R10";
        setup(3, 3, 5, 5);
        wr(1, 2);
        wr(0, 5);
        base = tog_cnt;
        idle(100);
        check(tog_cnt - base == 0, "R7", "idle before trigger", tog_cnt - base, 0);
        ext_in = 1; idle(20);
        check(tog_cnt - base == 0, "R10", "rising edge ignored", tog_cnt - base, 0);
        ext_in = 0; idle(30);
        check(tog_cnt - base >= 2, "R7", "counting after falling edge", tog_cnt - base, 2);

        // R11: input interrupt only while stopped (rising edge)
        cur_req = "R11";
        wr(0, 0); wr(1, 0);
        wr(0, 8);
        base = xirq_cnt;
        ext_in = 1; idle(6); ext_in = 0; idle(6);
        check(xirq_cnt - base == 1, "R11", "pulses while stopped", xirq_cnt - base, 1);
        wr(0, 9);
        base = xirq_cnt;
        ext_in = 1; idle(6); ext_in = 0; idle(6);
        check(xirq_cnt - base == 0, "R11", "pulses while running", xirq_cnt - base, 0);

        // R9: external count clock
        cur_req = "R9";
        setup(1, 1, 5, 5);
        wr(1, 1);
        eclk_on = 1;
        wr(0, 1);
        measure(1, w); check(w == 16, "R9", "high width on ext clock", w, 16);
        measure(0, w); check(w == 16, "R9", "low width on ext clock", w, 16);
        eclk_on = 0;
        wr(0, 0);
        idle(10);

        finish_run();
    end
endmodule